// File: doc/BRIEF.md
# Codec Host DMA Request Controller

This block sits between the host bus and the sample paths of a stereo audio codec. It moves samples in both directions as byte-wide bus transfers. When the playback path has an empty slot, or the capture path holds a new sample, the block raises the matching data-request line. The host answers by pulling the matching acknowledge low. It then issues one read or write strobe per byte until the whole sample has moved. The block counts those strobes against the current sample format. It emits a one-cycle transfer pulse with the byte lane for each byte, and it drops the request on the falling edge of the last strobe of the sample.

A shared-channel mode lets a host with only one DMA channel run capture through the playback request and acknowledge pair. Clearing an enable bit never cuts a sample short: a pending request still completes one full sample. A sample counter decrements once for every completed sample. When it underflows, it reloads from a base value and latches an interrupt until the host clears it.

Top module: `codec_dma_ctrl`

## Requirements
- R1: A direction raises its request only when its enable bit is 1, its programmed-I/O bit is 0, its slot-ready input is 1, and it has no request outstanding; with the PIO bit at 1 or the enable bit at 0, the request stays low.
- R2: Acknowledges are active low and pass through a two-flop synchronizer. Playback bytes are moved by falling edges of the write strobe, and capture bytes by falling edges of the read strobe. A strobe edge counts only while that direction's request is high and its acknowledge is low.
- R3: A request, once high, stays high until the falling strobe edge of the last byte of one sample. Bytes per sample follow the format input: 0 gives 1 byte, 1 and 2 give 2 bytes, and 3 gives 4 bytes.
- R4: Each counted byte produces a one-cycle pulse on the direction's transfer output three clock edges after the strobe falls. The lane output carries the byte index at the same time: it runs 0, 1, 2 and so on within a sample and returns to 0 for the next sample.
- R5: With the single-channel bit at 1, capture requests appear on the playback request output and are acknowledged on the playback acknowledge input. The capture request output stays low and the capture acknowledge input has no effect.
- R6: In single-channel mode with both enable bits at 1, the channel serves playback only, and a capture slot raises no request.
- R7: Clearing an enable bit while its request is high does not drop the request. The remaining bytes of that sample still complete it, and no new request follows.
- R8: The sample counter resets to 0 and decrements once per completed sample. A sample that completes while it is 0 underflows the counter: it reloads the base-count input and sets the interrupt.
- R9: The interrupt stays high until a one-cycle pulse on the clear input, and the clear takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_en_i | input | 1 | Playback enable |
| play_pio_i | input | 1 | Playback programmed-I/O select (1 = no DMA) |
| cap_en_i | input | 1 | Capture enable |
| cap_pio_i | input | 1 | Capture programmed-I/O select (1 = no DMA) |
| single_ch_i | input | 1 | Single-channel mode |
| fmt_i | input | 2 | Sample format selecting bytes per sample |
| play_slot_i | input | 1 | Playback buffer has an empty slot |
| cap_slot_i | input | 1 | Capture sample available |
| rd_ni | input | 1 | Host read strobe, active low |
| wr_ni | input | 1 | Host write strobe, active low |
| play_ack_ni | input | 1 | Playback acknowledge, active low |
| cap_ack_ni | input | 1 | Capture acknowledge, active low |
| base_count_i | input | CNT_W | Counter reload value |
| irq_clr_i | input | 1 | Interrupt clear pulse |
| play_req_o | output | 1 | Playback (or shared) data request |
| cap_req_o | output | 1 | Capture data request |
| lane_o | output | 2 | Byte index of the byte just moved |
| play_xfer_o | output | 1 | Playback byte moved |
| cap_xfer_o | output | 1 | Capture byte moved |
| irq_o | output | 1 | Counter-underflow interrupt |

## Verification
The bench builds the block with CNT_W at 4 and drives a base count of 2. With that setting the counter underflows on the first sample and again every three samples, so both reload and repeated interrupts show up within six samples. The formats cover one-, two- and four-byte samples, which exercises lane wrap, the mid-sample request hold and an abort after the first byte. Single-channel runs check the request folding and show that strobes under the wrong acknowledge move nothing.

// File: rtl/codec_dma_pkg.sv
package codec_dma_pkg;
  localparam int unsigned MAX_BYTES = 4;
  localparam int unsigned LANE_W    = $clog2(MAX_BYTES);
  localparam int unsigned NB_W      = LANE_W + 1;
  localparam int unsigned N_DIR     = 2;
  localparam int unsigned DIR_PLAY  = 0;
  localparam int unsigned DIR_CAP   = 1;

  typedef enum logic [1:0] {
    FMT_8M  = 2'd0,
    FMT_8S  = 2'd1,
    FMT_16M = 2'd2,
    FMT_16S = 2'd3
  } fmt_e;

  function automatic logic [NB_W-1:0] bytes_per_sample(input fmt_e f);
    case (f)
      FMT_8M:  return NB_W'(1);
      FMT_8S:  return NB_W'(2);
      FMT_16M: return NB_W'(2);
      default: return NB_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/codec_dma_sync.sv
module codec_dma_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  // inputs are active low: idle level 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '1;
    else         st_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '1;
      else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/codec_dma_dir.sv
module codec_dma_dir
  import codec_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              elig_i,
  input  logic              slot_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic              fall_i,
  input  logic              ack_lo_i,
  output logic              req_o,
  output logic              xfer_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              done_o
);
  logic              req_q, xfer_q;
  logic [LANE_W-1:0] idx_q, lane_q;
  logic              byte_ev, last;

  assign byte_ev = req_q & ack_lo_i & fall_i;
  assign last    = ({1'b0, idx_q} + NB_W'(1)) >= nbytes_i;
  assign done_o  = byte_ev & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      idx_q  <= '0;
      xfer_q <= 1'b0;
      lane_q <= '0;
    end else begin
      xfer_q <= byte_ev;
      if (done_o)                        req_q <= 1'b0;
      else if (!req_q && elig_i && slot_i) req_q <= 1'b1;
      if (byte_ev) begin
        lane_q <= idx_q;
        idx_q  <= last ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign req_o  = req_q;
  assign xfer_o = xfer_q;
  assign lane_o = lane_q;

  // R3: request holds until the final byte of the sample
  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !done_o) |=> req_q);
  // R1: a request rises only from an eligible, ready direction
  a_r1_req_needs_elig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(elig_i && slot_i));
  // R4: byte index rests at zero between samples
  a_r4_lane_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q |-> (idx_q == '0));
endmodule

// File: rtl/codec_dma_irq.sv
module codec_dma_irq #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       done_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       dec;
  logic [CNT_W:0]   diff;
  logic             under;

  assign dec   = {1'b0, done_i[0]} + {1'b0, done_i[1]};
  assign diff  = {1'b0, cnt_q} - (CNT_W+1)'(dec);
  assign under = diff[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (dec != 2'd0) begin
        if (under) cnt_q <= base_i + diff[CNT_W-1:0] + CNT_W'(1);
        else       cnt_q <= diff[CNT_W-1:0];
      end
      if (dec != 2'd0 && under) irq_o <= 1'b1;
      else if (clr_i)           irq_o <= 1'b0;
    end
  end

  // R8: underflow raises the interrupt
  a_r8_underflow_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i != 2'b00 && cnt_q == '0) |=> irq_o);
  // R9: interrupt holds until cleared
  a_r9_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/codec_dma_ctrl.sv
module codec_dma_ctrl
  import codec_dma_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              play_en_i,
  input  logic              play_pio_i,
  input  logic              cap_en_i,
  input  logic              cap_pio_i,
  input  logic              single_ch_i,
  input  logic [1:0]        fmt_i,
  input  logic              play_slot_i,
  input  logic              cap_slot_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              play_ack_ni,
  input  logic              cap_ack_ni,
  input  logic [CNT_W-1:0]  base_count_i,
  input  logic              irq_clr_i,
  output logic              play_req_o,
  output logic              cap_req_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              play_xfer_o,
  output logic              cap_xfer_o,
  output logic              irq_o
);
  logic [3:0]        sync_q;
  logic              rd_s, wr_s, pack_s, cack_s;
  logic              rd_prev_q, wr_prev_q;
  logic              rd_fall, wr_fall;
  logic [NB_W-1:0]   nbytes;

  logic              elig   [N_DIR];
  logic              slot   [N_DIR];
  logic              fall   [N_DIR];
  logic              ack_lo [N_DIR];
  logic              req    [N_DIR];
  logic              xfer   [N_DIR];
  logic [LANE_W-1:0] lane   [N_DIR];
  logic [1:0]        done;

  codec_dma_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cap_ack_ni, play_ack_ni, wr_ni, rd_ni}),
    .q_o    (sync_q)
  );
  assign {cack_s, pack_s, wr_s, rd_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
    end else begin
      rd_prev_q <= rd_s;
      wr_prev_q <= wr_s;
    end
  end
  assign rd_fall = rd_prev_q & ~rd_s;
  assign wr_fall = wr_prev_q & ~wr_s;

  assign nbytes = bytes_per_sample(fmt_e'(fmt_i));

  // shared channel presumes playback when both directions are enabled
  assign elig[DIR_PLAY]   = play_en_i & ~play_pio_i;
  assign elig[DIR_CAP]    = cap_en_i & ~cap_pio_i & ~(single_ch_i & play_en_i);
  assign slot[DIR_PLAY]   = play_slot_i;
  assign slot[DIR_CAP]    = cap_slot_i;
  assign fall[DIR_PLAY]   = wr_fall;
  assign fall[DIR_CAP]    = rd_fall;
  assign ack_lo[DIR_PLAY] = ~pack_s;
  assign ack_lo[DIR_CAP]  = single_ch_i ? ~pack_s : ~cack_s;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    codec_dma_dir u_dir (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .elig_i   (elig[d]),
      .slot_i   (slot[d]),
      .nbytes_i (nbytes),
      .fall_i   (fall[d]),
      .ack_lo_i (ack_lo[d]),
      .req_o    (req[d]),
      .xfer_o   (xfer[d]),
      .lane_o   (lane[d]),
      .done_o   (done[d])
    );
  end

  codec_dma_irq #(.CNT_W(CNT_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .base_i (base_count_i),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  assign play_req_o  = req[DIR_PLAY] | (single_ch_i & req[DIR_CAP]);
  assign cap_req_o   = req[DIR_CAP] & ~single_ch_i;
  assign play_xfer_o = xfer[DIR_PLAY];
  assign cap_xfer_o  = xfer[DIR_CAP];
  assign lane_o      = xfer[DIR_CAP] ? lane[DIR_CAP] : lane[DIR_PLAY];

  // R5: capture acknowledge cannot move a byte in single-channel mode
  a_r5_single_cap_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_ch_i && $past(single_ch_i) && pack_s && $past(pack_s)) |=> !cap_xfer_o);
endmodule

// File: tb/sim_codec_dma_ctrl.sv
module sim_codec_dma_ctrl;
  localparam int CNT_W = 4;
  localparam int BASE  = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic play_en_i = 0, play_pio_i = 0, cap_en_i = 0, cap_pio_i = 0, single_ch_i = 0;
  logic [1:0] fmt_i = 2'd0;
  logic play_slot_i = 0, cap_slot_i = 0;
  logic rd_ni = 1, wr_ni = 1, play_ack_ni = 1, cap_ack_ni = 1;
  logic [CNT_W-1:0] base_count_i = CNT_W'(BASE);
  logic irq_clr_i = 0;
  logic play_req_o, cap_req_o, play_xfer_o, cap_xfer_o, irq_o;
  logic [1:0] lane_o;

  int n_chk = 0, n_fail = 0;
  int exp_cnt = 0;
  logic [2:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  codec_dma_ctrl #(.CNT_W(CNT_W)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: every byte pulse must match the next expected item
  always @(negedge clk_i) begin
    if (rst_ni && (play_xfer_o || cap_xfer_o)) begin
      logic [2:0] got;
      got = {cap_xfer_o, lane_o};
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", int'(got), -1);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check(got == e, "R4 byte dir/lane", int'(got), int'(e));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic strobe(input bit cap);
    if (cap) rd_ni = 1'b0; else wr_ni = 1'b0;
    cyc(4);
    rd_ni = 1'b1; wr_ni = 1'b1;
    cyc(4);
  endtask

  task automatic byte_xfer(input bit cap, input logic [1:0] lane);
    exp_q.push_back({cap, lane});
    strobe(cap);
  endtask

  task automatic pulse_slot(input bit cap);
    if (cap) cap_slot_i = 1'b1; else play_slot_i = 1'b1;
    cyc(1);
    cap_slot_i = 1'b0; play_slot_i = 1'b0;
    cyc(1);
  endtask

  // sample completed: model counter and interrupt (R8, R9)
  task automatic sample_end();
    bit exp_irq;
    exp_irq = (exp_cnt == 0);
    exp_cnt = exp_irq ? BASE : exp_cnt - 1;
    check(irq_o == exp_irq, "R8 irq after sample", irq_o, exp_irq);
    if (exp_irq) begin
      cyc(3);
      check(irq_o == 1'b1, "R9 irq held", irq_o, 1);
      irq_clr_i = 1'b1; cyc(1); irq_clr_i = 1'b0;
      check(irq_o == 1'b0, "R9 irq cleared", irq_o, 0);
    end
  endtask

  initial begin
    cyc(20000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    cyc(2);
    check(!play_req_o && !cap_req_o && !irq_o, "reset state", {play_req_o, cap_req_o, irq_o}, 0);
    rst_ni = 1'b1;
    cyc(2);

    // R1: PIO selected or disabled gives no request
    play_en_i = 1; play_pio_i = 1;
    pulse_slot(0);
    check(play_req_o == 0, "R1 pio blocks", play_req_o, 0);
    play_pio_i = 0; play_en_i = 0;
    pulse_slot(0);
    check(play_req_o == 0, "R1 disabled blocks", play_req_o, 0);

    // R1/R3: one-byte playback sample
    play_en_i = 1; fmt_i = 2'd0;
    pulse_slot(0);
    check(play_req_o == 1, "R1 play request", play_req_o, 1);
    play_ack_ni = 0; cyc(3);
    byte_xfer(0, 2'd0);
    check(play_req_o == 0, "R3 drop after 1-byte sample", play_req_o, 0);
    sample_end();

    // R2: strobes without acknowledge move nothing
    play_ack_ni = 1; cyc(3);
    pulse_slot(0);
    strobe(0);
    check(play_req_o == 1, "R2 no ack keeps request", play_req_o, 1);
    cap_ack_ni = 0; cyc(3);
    strobe(0);
    check(play_req_o == 1, "R2 wrong ack ignored", play_req_o, 1);
    cap_ack_ni = 1; play_ack_ni = 0; cyc(3);
    byte_xfer(0, 2'd0);
    check(play_req_o == 0, "R2 ack completes", play_req_o, 0);
    sample_end();
    play_ack_ni = 1; play_en_i = 0; cyc(3);

    // R3/R4: four-byte capture sample
    cap_en_i = 1; fmt_i = 2'd3;
    pulse_slot(1);
    check(cap_req_o == 1 && play_req_o == 0, "R1 cap request", cap_req_o, 1);
    cap_ack_ni = 0; cyc(3);
    for (int i = 0; i < 3; i++) begin
      byte_xfer(1, 2'(i));
      check(cap_req_o == 1, "R3 held mid-sample", cap_req_o, 1);
    end
    byte_xfer(1, 2'd3);
    check(cap_req_o == 0, "R3 drop after last byte", cap_req_o, 0);
    sample_end();
    cap_ack_ni = 1; cap_en_i = 0; cyc(3);

    // R7: abort mid two-byte playback sample
    play_en_i = 1; fmt_i = 2'd1;
    pulse_slot(0);
    play_ack_ni = 0; cyc(3);
    byte_xfer(0, 2'd0);
    play_en_i = 0; cyc(2);
    check(play_req_o == 1, "R7 request survives abort", play_req_o, 1);
    byte_xfer(0, 2'd1);
    check(play_req_o == 0, "R7 final sample done", play_req_o, 0);
    sample_end();
    pulse_slot(0);
    check(play_req_o == 0, "R7 no new request", play_req_o, 0);
    play_ack_ni = 1; cyc(3);

    // R5: single-channel capture folding
    single_ch_i = 1; cap_en_i = 1; fmt_i = 2'd0;
    pulse_slot(1);
    check(play_req_o == 1 && cap_req_o == 0, "R5 capture on play request",
          {play_req_o, cap_req_o}, 2);
    cap_ack_ni = 0; cyc(3);
    strobe(1);
    check(play_req_o == 1, "R5 cap ack ignored", play_req_o, 1);
    cap_ack_ni = 1; play_ack_ni = 0; cyc(3);
    byte_xfer(1, 2'd0);
    check(play_req_o == 0, "R5 served via play ack", play_req_o, 0);
    sample_end();
    play_ack_ni = 1; cyc(3);

    // R6: both enabled in single mode means playback
    play_en_i = 1;
    pulse_slot(1);
    check(play_req_o == 0 && cap_req_o == 0, "R6 capture suppressed",
          {play_req_o, cap_req_o}, 0);
    pulse_slot(0);
    check(play_req_o == 1, "R6 playback served", play_req_o, 1);
    play_ack_ni = 0; cyc(3);
    byte_xfer(0, 2'd0);
    check(play_req_o == 0, "R6 playback done", play_req_o, 0);
    sample_end();

    cyc(4);
    check(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule